// File: doc/BRIEF.md
# Partitionable Mixed-Sign Multiplier Array

This block is a two-stage pipelined multiplier array whose operand buses can be split three ways. It can act as eight independent 9x9 multipliers, four independent 18x18 multipliers, or a single 36x36 multiplier. Two run-time control bits say whether the A operands and the B operands are two's-complement or unsigned. Each control bit covers every sub-multiplier in the array together. Every product is kept at full precision, so no sign combination can overflow.

Operands, mode and sign bits are all captured in the input register stage. The products are registered one stage later. A valid flag travels through the pipeline with the data, and one clock enable moves both stages forward. The A input register can also act as a shift chain: each sub-multiplier's A segment then takes the segment below it, and the lowest segment loads from the bus. This lets one operand be spread across several taps without driving the bus for each one.

Top module: `pmul_array`

## Requirements
- R1: With `mode` = 2'b00, for every lane k from 0 to 7, `prod[18k+17:18k]` is the product of `a_bus[9k+8:9k]` and `b_bus[9k+8:9k]`.
- R2: With `mode` = 2'b01, for every k from 0 to 3, `prod[36k+35:36k]` is the product of `a_bus[18k+17:18k]` and `b_bus[18k+17:18k]`.
- R3: With `mode` = 2'b10 or 2'b11, `prod[71:0]` is the product of `a_bus[35:0]` and `b_bus[35:0]`. `prod[143:72]` is zero, and operand bits 71:36 have no effect.
- R4: `a_signed`=1 makes every A operand two's complement, and `a_signed`=0 makes it unsigned. `b_signed` does the same for B. Each sub-product is the exact mathematical product, written in 2N bits for N-bit operands.
- R5: One pair of sign bits applies to every sub-multiplier at once. The sub-products are still computed independently of each other.
- R6: When the clock enable is high on two edges in a row, `prod` and `out_vld` on the second edge reflect the inputs sampled on the first edge, and `out_vld` copies `in_vld`.
- R7: The mode and sign bits are captured with the operands. Changing them later does not alter a product already in the pipeline.
- R8: With `shift_en`=1 on a capture edge, let S be the sub-multiplier width of the mode sampled on that edge. The A register shifts up by S bits, and its low S bits load from `a_bus[S-1:0]`. The B register still loads in parallel.
- R9: With `ce`=0, no register changes, so `prod` and `out_vld` stay stable.
- R10: Synchronous reset clears all operand, sign, mode and valid registers and the product register. The edge after reset shows `prod`=0 and `out_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for both pipeline stages |
| in_vld | input | 1 | Input sample valid |
| mode | input | 2 | 00: eight 9x9, 01: four 18x18, 1x: one 36x36 |
| a_signed | input | 1 | A operands are two's complement when 1 |
| b_signed | input | 1 | B operands are two's complement when 1 |
| shift_en | input | 1 | A register loads from the chain instead of the bus |
| a_bus | input | 72 | Packed A operands |
| b_bus | input | 72 | Packed B operands |
| out_vld | output | 1 | Product valid |
| prod | output | 144 | Packed full-precision products |

## Verification
The checker asserts on every cycle:
- the cleared state after reset,
- the freeze under a low clock enable,
- the two-edge valid latency,
- the zero upper half of the product in 36-bit mode,
- the 9-bit shift-chain step of the A register.

The arithmetic needs the bench scenarios, which compare each packed product against an independent reference. Those scenarios cover:
- every mode and all four sign combinations;
- the most negative, largest and unit operands;
- modes and signs that change every cycle while products are in flight;
- long shift runs.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  localparam logic [1:0] PM_NARROW = 2'b00;
  localparam logic [1:0] PM_MID    = 2'b01;
  localparam logic [1:0] PM_WIDE   = 2'b10;

  // 36-bit mode is selected by the upper mode bit alone
  function automatic logic pm_is_wide(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/pmul_lane.sv
module pmul_lane #(
  parameter int W = 9
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sa,
  input  logic           sb,
  output logic [2*W-1:0] p
);
  // One extra bit turns either sign convention into a signed operand
  logic signed [W:0]     ea, eb;
  logic signed [2*W-1:0] xa, xb;

  assign ea = $signed({sa & a[W-1], a});
  assign eb = $signed({sb & b[W-1], b});
  // Products modulo 2^(2W) are exact because the true result fits
  assign xa = $signed({{(W-1){ea[W]}}, ea});
  assign xb = $signed({{(W-1){eb[W]}}, eb});
  assign p  = xa * xb;
endmodule

// File: rtl/pmul_capture.sv
module pmul_capture
  import pmul_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce,
  input  logic                     in_vld,
  input  logic [1:0]               mode_in,
  input  logic                     a_signed,
  input  logic                     b_signed,
  input  logic                     shift_en,
  input  logic [LANE_W*LANES-1:0]  a_bus,
  input  logic [LANE_W*LANES-1:0]  b_bus,
  output logic [LANE_W*LANES-1:0]  a_q,
  output logic [LANE_W*LANES-1:0]  b_q,
  output logic                     sa_q,
  output logic                     sb_q,
  output logic [1:0]               mode_q,
  output logic                     vld_q
);
  localparam int AW = LANE_W * LANES;
  localparam int MW = 2 * LANE_W;
  localparam int WW = 4 * LANE_W;

  logic [AW-1:0] a_next;

  always_comb begin
    a_next = a_bus;
    if (shift_en) begin
      if (pm_is_wide(mode_in))
        a_next = {a_q[AW-WW-1:0], a_bus[WW-1:0]};
      else if (mode_in == PM_MID)
        a_next = {a_q[AW-MW-1:0], a_bus[MW-1:0]};
      else
        a_next = {a_q[AW-LANE_W-1:0], a_bus[LANE_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      sa_q   <= 1'b0;
      sb_q   <= 1'b0;
      mode_q <= PM_NARROW;
      vld_q  <= 1'b0;
    end else if (ce) begin
      a_q    <= a_next;
      b_q    <= b_bus;
      sa_q   <= a_signed;
      sb_q   <= b_signed;
      mode_q <= mode_in;
      vld_q  <= in_vld;
    end
  end
endmodule

// File: rtl/pmul_core.sv
module pmul_core
  import pmul_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 8
) (
  input  logic [LANE_W*LANES-1:0]   a,
  input  logic [LANE_W*LANES-1:0]   b,
  input  logic                      sa,
  input  logic                      sb,
  input  logic [1:0]                mode,
  output logic [2*LANE_W*LANES-1:0] prod_d
);
  localparam int AW   = LANE_W * LANES;
  localparam int PW   = 2 * AW;
  localparam int MW   = 2 * LANE_W;
  localparam int WW   = 4 * LANE_W;
  localparam int MIDS = LANES / 2;

  logic [PW-1:0]   p_narrow;
  logic [PW-1:0]   p_mid;
  logic [2*WW-1:0] p_wide;

  for (genvar k = 0; k < LANES; k++) begin : g_narrow
    pmul_lane #(.W(LANE_W)) u_lane (
      .a (a[k*LANE_W +: LANE_W]),
      .b (b[k*LANE_W +: LANE_W]),
      .sa(sa),
      .sb(sb),
      .p (p_narrow[k*2*LANE_W +: 2*LANE_W])
    );
  end

  for (genvar k = 0; k < MIDS; k++) begin : g_mid
    pmul_lane #(.W(MW)) u_lane (
      .a (a[k*MW +: MW]),
      .b (b[k*MW +: MW]),
      .sa(sa),
      .sb(sb),
      .p (p_mid[k*2*MW +: 2*MW])
    );
  end

  pmul_lane #(.W(WW)) u_wide (
    .a (a[WW-1:0]),
    .b (b[WW-1:0]),
    .sa(sa),
    .sb(sb),
    .p (p_wide)
  );

  always_comb begin
    if (pm_is_wide(mode))
      prod_d = {{(PW-2*WW){1'b0}}, p_wide};
    else if (mode == PM_MID)
      prod_d = p_mid;
    else
      prod_d = p_narrow;
  end
endmodule

// File: rtl/pmul_array.sv
module pmul_array #(
  parameter int LANE_W = 9,
  parameter int LANES  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ce,
  input  logic                      in_vld,
  input  logic [1:0]                mode,
  input  logic                      a_signed,
  input  logic                      b_signed,
  input  logic                      shift_en,
  input  logic [LANE_W*LANES-1:0]   a_bus,
  input  logic [LANE_W*LANES-1:0]   b_bus,
  output logic                      out_vld,
  output logic [2*LANE_W*LANES-1:0] prod
);
  localparam int AW = LANE_W * LANES;
  localparam int PW = 2 * AW;

  // Stage-one state, named for the checker
  logic [AW-1:0] stg_a, stg_b;
  logic          stg_sa, stg_sb, stg_vld;
  logic [1:0]    stg_mode;
  logic [PW-1:0] prod_d;

  pmul_capture #(.LANE_W(LANE_W), .LANES(LANES)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .in_vld  (in_vld),
    .mode_in (mode),
    .a_signed(a_signed),
    .b_signed(b_signed),
    .shift_en(shift_en),
    .a_bus   (a_bus),
    .b_bus   (b_bus),
    .a_q     (stg_a),
    .b_q     (stg_b),
    .sa_q    (stg_sa),
    .sb_q    (stg_sb),
    .mode_q  (stg_mode),
    .vld_q   (stg_vld)
  );

  pmul_core #(.LANE_W(LANE_W), .LANES(LANES)) u_core (
    .a     (stg_a),
    .b     (stg_b),
    .sa    (stg_sa),
    .sb    (stg_sb),
    .mode  (stg_mode),
    .prod_d(prod_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prod    <= '0;
      out_vld <= 1'b0;
    end else if (ce) begin
      prod    <= prod_d;
      out_vld <= stg_vld;
    end
  end
endmodule

// File: rtl/pmul_array_chk.sv
module pmul_array_chk #(
  parameter int LANE_W = 9,
  parameter int LANES  = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      ce,
  input logic                      in_vld,
  input logic [1:0]                mode,
  input logic                      shift_en,
  input logic [LANE_W*LANES-1:0]   a_bus,
  input logic [LANE_W*LANES-1:0]   stg_a,
  input logic                      out_vld,
  input logic [2*LANE_W*LANES-1:0] prod
);
  localparam int PW = 2 * LANE_W * LANES;
  localparam int WP = 8 * LANE_W;

  // Counts clean edges since reset so that $past never reaches into reset
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!out_vld && prod == '0));

  assert_hold_on_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(prod) && $stable(out_vld)));

  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && $past(ce) && $past(ce, 2)) |-> (out_vld == $past(in_vld, 2)));

  assert_wide_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && $past(ce) && $past(ce, 2) && $past(mode[1], 2))
      |-> (prod[PW-1:WP] == '0));

  assert_chain_step_R8: assert property (@(posedge clk) disable iff (rst)
    (ce && shift_en && mode == 2'b00)
      |=> (stg_a[2*LANE_W-1:LANE_W] == $past(stg_a[LANE_W-1:0])
           && stg_a[LANE_W-1:0] == $past(a_bus[LANE_W-1:0])));
endmodule

bind pmul_array pmul_array_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ce      (ce),
  .in_vld  (in_vld),
  .mode    (mode),
  .shift_en(shift_en),
  .a_bus   (a_bus),
  .stg_a   (stg_a),
  .out_vld (out_vld),
  .prod    (prod)
);

// File: tb/sim_pmul_array.sv
`timescale 1ns/1ps
module sim_pmul_array;
  localparam int AW = 72;
  localparam int PW = 144;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce = 1'b0;
  logic          in_vld = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          a_signed = 1'b0;
  logic          b_signed = 1'b0;
  logic          shift_en = 1'b0;
  logic [AW-1:0] a_bus = '0;
  logic [AW-1:0] b_bus = '0;
  logic          out_vld;
  logic [PW-1:0] prod;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_tag = "R10";

  // Bench model state
  logic [AW-1:0] m_a, m_b;
  logic          m_sa, m_sb, m_vld, e_vld;
  logic [1:0]    m_mode;
  logic [PW-1:0] e_prod;

  always #2.5 clk = ~clk;

  pmul_array u0 (
    .clk(clk), .rst(rst), .ce(ce), .in_vld(in_vld), .mode(mode),
    .a_signed(a_signed), .b_signed(b_signed), .shift_en(shift_en),
    .a_bus(a_bus), .b_bus(b_bus), .out_vld(out_vld), .prod(prod)
  );

  function automatic int sub_w(input logic [1:0] md);
    return md[1] ? 36 : (md[0] ? 18 : 9);
  endfunction

  // Reference product built with wide signed integers field by field
  function automatic logic [PW-1:0] ref_prod(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                             input logic [1:0] md, input logic sa, input logic sb);
    logic signed [79:0] one, ai, bi, pp;
    logic [PW-1:0] r;
    int w, n;
    one = 80'sd1;
    r = '0;
    w = sub_w(md);
    n = 72 / w;
    if (md[1]) n = 1;
    for (int k = 0; k < n; k++) begin
      ai = $signed({8'd0, a} >> (k * w)) & ((one << w) - one);
      bi = $signed({8'd0, b} >> (k * w)) & ((one << w) - one);
      if (sa && ai[w-1]) ai = ai - (one << w);
      if (sb && bi[w-1]) bi = bi - (one << w);
      pp = ai * bi;
      pp = pp & ((one << (2 * w)) - one);
      r = r | (PW'(pp) << (k * 2 * w));
    end
    return r;
  endfunction

  function automatic logic [AW-1:0] rnd72();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] fill(input int code, input int w, input int n);
    logic [AW-1:0] r, v;
    r = '0;
    case (code)
      0: v = AW'(1) << (w - 1);                 // most negative when signed
      1: v = (AW'(1) << w) - AW'(1);            // all ones
      2: v = (AW'(1) << (w - 1)) - AW'(1);      // largest positive
      default: v = AW'(1);
    endcase
    for (int k = 0; k < n; k++) r = r | (v << (k * w));
    return r;
  endfunction

  task automatic cyc();
    int w;
    @(posedge clk);
    if (rst) begin
      m_a = '0; m_b = '0; m_sa = 1'b0; m_sb = 1'b0; m_mode = 2'b00; m_vld = 1'b0;
      e_prod = '0; e_vld = 1'b0;
    end else if (ce) begin
      e_prod = ref_prod(m_a, m_b, m_mode, m_sa, m_sb);
      e_vld  = m_vld;
      w = sub_w(mode);
      if (shift_en) m_a = (m_a << w) | (a_bus & ((AW'(1) << w) - AW'(1)));
      else          m_a = a_bus;
      m_b = b_bus; m_sa = a_signed; m_sb = b_signed; m_mode = mode; m_vld = in_vld;
    end
    @(negedge clk);
    n_chk++;
    if (prod !== e_prod || out_vld !== e_vld) begin
      n_bad++;
      $display("FAIL %s prod=%h vld=%b expected prod=%h vld=%b", cur_tag, prod, out_vld, e_prod, e_vld);
    end
  endtask

  initial begin
    void'($urandom(32'd4177));
    // Reset state
    cur_tag = "R10";
    rst = 1'b1;
    repeat (3) cyc();
    rst = 1'b0; ce = 1'b1;
    repeat (2) cyc();

    // Directed corners: every mode and sign pair, extreme operands
    for (int md = 0; md < 4; md++) begin
      for (int s = 0; s < 4; s++) begin
        for (int ca = 0; ca < 4; ca++) begin
          for (int cb = 0; cb < 4; cb++) begin
            int w, n;
            mode = 2'(md);
            cur_tag = (md == 0) ? "R1 R4" : (md == 1) ? "R2 R4" : "R3 R4";
            w = sub_w(mode);
            n = md[1] ? 1 : 72 / w;
            a_signed = s[1]; b_signed = s[0];
            a_bus = fill(ca, w, n);
            b_bus = fill(cb, w, n);
            if (md[1]) begin
              a_bus[71:36] = rnd72()[35:0];
              b_bus[71:36] = rnd72()[35:0];
            end
            in_vld = 1'b1; shift_en = 1'b0; ce = 1'b1;
            cyc();
          end
        end
      end
    end

    // Random data with mode and signs changing every cycle
    cur_tag = "R5 R6 R7";
    for (int i = 0; i < 600; i++) begin
      mode = 2'($urandom_range(0, 3));
      a_signed = 1'($urandom()); b_signed = 1'($urandom());
      a_bus = rnd72(); b_bus = rnd72();
      in_vld = 1'($urandom());
      ce = ($urandom_range(0, 9) != 0);
      shift_en = 1'b0;
      cyc();
    end

    // Shift chain runs in each mode
    cur_tag = "R8";
    ce = 1'b1;
    for (int md = 0; md < 3; md++) begin
      for (int i = 0; i < 20; i++) begin
        mode = 2'(md);
        shift_en = (i != 0);
        a_signed = 1'($urandom()); b_signed = 1'($urandom());
        a_bus = rnd72(); b_bus = rnd72(); in_vld = 1'b1;
        cyc();
      end
    end
    shift_en = 1'b0;

    // Clock enable low while inputs churn
    cur_tag = "R9";
    for (int i = 0; i < 30; i++) begin
      ce = (i % 6 == 5);
      mode = 2'($urandom_range(0, 3));
      a_signed = 1'($urandom()); b_signed = 1'($urandom());
      a_bus = rnd72(); b_bus = rnd72(); in_vld = 1'($urandom());
      shift_en = 1'($urandom());
      cyc();
    end

    // Reset in the middle of traffic
    cur_tag = "R10";
    ce = 1'b1; shift_en = 1'b0;
    rst = 1'b1;
    cyc();
    rst = 1'b0; in_vld = 1'b0; a_bus = '0; b_bus = '0;
    repeat (3) cyc();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R6 watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule